// File: doc/BRIEF.md
# Parallel Camera Capture Front End

This block takes an 8-bit parallel camera bus into the system clock domain and turns it into a stream of 16-bit pixel words, with single-cycle pulses that mark where frames and lines begin and end. The camera pixel clock is oversampled by the system clock. A configuration input picks which pixel clock edge captures data. Either edge can be used.

Line and frame boundaries come from one of two places, chosen by a mode input. In external mode they come from horizontal and vertical sync lines, and the polarity of each line is programmable. In embedded mode they come from four-byte code sequences carried inside the data. Each sequence is an all-ones byte, two all-zero bytes and then a code byte. Four code bytes and four per-bit unmask bytes are programmable. If both frame code fields hold all ones, frame limits are inferred from idle gaps between lines.

Pixel bytes are paired into words, and an option swaps the byte order of each pair. An enable input gates all capture.

Top module: `cam_par_rx`

## Requirements
- R1: While `cfg_enable` is low, or in reset, `out_valid` and all four flag outputs stay low, and the line, frame and pairing state is cleared.
- R2: `cfg_pclk_rise`=1 captures a byte on each low-to-high transition of `pix_clk`. `cfg_pclk_rise`=0 captures on each high-to-low transition. The other transition captures nothing.
- R3: In external mode (`cfg_embedded`=0), a sync line counts as active when its level equals its polarity input (`cfg_hs_high`, `cfg_vs_high`). Bytes are captured only while both sync lines are active.
- R4: In external mode, `out_sof` pulses when the vertical sync becomes active and `out_eof` pulses when it goes inactive. `out_sol` and `out_eol` pulse when the line-active condition (both syncs active) starts and stops. A frame start and a frame end never pulse in the same cycle.
- R5: `cfg_codes` and `cfg_unmask` each hold four byte fields: bits [7:0] frame start, [15:8] line start, [23:16] line end, [31:24] frame end. A received byte hits a field when ((byte XOR code) AND unmask) is zero.
- R6: In embedded mode, a code byte that follows FF 00 00 and hits a field is a sync code. The preamble and the code byte never reach the output. When several fields hit, line start wins over line end, which wins over frame start, then frame end. Only bytes received between a line start and a line end are emitted.
- R7: When fields [31:24] and [7:0] are both 0xFF, frame codes are ignored. A line start received while no frame is open also pulses `out_sof`. Once a frame is open and outside a line, `out_eof` pulses on the captured byte that makes the idle count exceed `cfg_gap` after the last line end.
- R8: When the frame fields are not both 0xFF, a frame-start code pulses `out_sof`. A frame-end code pulses `out_eof` and closes any open line with `out_eol`.
- R9: Two bytes in a line make one word. With `cfg_swap`=0 the first byte fills bits [7:0]. Pairing restarts at each line start, and an odd final byte of a line is dropped.
- R10: With `cfg_swap`=1 the first byte of each pair fills bits [15:8].
- R11: Clearing `cfg_enable` in the middle of a line discards that line. After enable returns, no bytes are emitted until a new line start.
- R12: In embedded mode, FF 00 00 followed by a byte that hits no active field is ordinary pixel data and passes through in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clk | input | 1 | Camera pixel clock, oversampled |
| pix_data | input | 8 | Camera data bus |
| hsync_in | input | 1 | External horizontal sync line |
| vsync_in | input | 1 | External vertical sync line |
| cfg_enable | input | 1 | Capture enable |
| cfg_embedded | input | 1 | 1: codes in data, 0: external sync lines |
| cfg_pclk_rise | input | 1 | 1: capture on rising pixel clock edge |
| cfg_hs_high | input | 1 | Horizontal sync active level |
| cfg_vs_high | input | 1 | Vertical sync active level |
| cfg_swap | input | 1 | Swap the two bytes of each word |
| cfg_codes | input | 32 | Frame end, line end, line start, frame start code bytes |
| cfg_unmask | input | 32 | Per-bit compare enables, same field layout |
| cfg_gap | input | 16 | Idle byte count that closes an inferred frame |
| out_valid | output | 1 | Word strobe |
| out_word | output | 16 | Paired pixel word |
| out_sol | output | 1 | Line start pulse |
| out_eol | output | 1 | Line end pulse |
| out_sof | output | 1 | Frame start pulse |
| out_eof | output | 1 | Frame end pulse |

## Verification
An external-sync frame with active-high syncs is compared against one with active-low syncs, falling-edge capture and swapped pairs. Junk data is placed on the bus at the wrong clock edge, so a wrong polarity shows up as bad words, and the swapped run shows whether the byte order inside a word is correct. In embedded mode, a stream with a short gap between lines and a long gap at the end separates the inferred frame end from a line end. That stream also carries FF 00 00 55 inside a line to show that a non-matching code is kept as data. An explicit-code stream uses a line-start code that only hits through its unmask byte, and a disable in mid-line followed by stray data shows that the line state is discarded.

// File: rtl/cam_rx_pkg.sv
package cam_rx_pkg;
  localparam int unsigned PIX_W   = 8;
  localparam int unsigned WORD_W  = 2 * PIX_W;
  localparam int unsigned CODES_W = 4 * PIX_W;

  // byte slot of each code inside the code and unmask words
  typedef enum logic [1:0] {
    SLOT_FS = 2'd0,
    SLOT_LS = 2'd1,
    SLOT_LE = 2'd2,
    SLOT_FE = 2'd3
  } code_slot_e;

  typedef struct packed {
    logic sof;
    logic sol;
    logic eol;
    logic eof;
  } cam_evt_t;

  function automatic logic code_hit(input logic [PIX_W-1:0]   rx,
                                    input logic [CODES_W-1:0] codes,
                                    input logic [CODES_W-1:0] unmask,
                                    input code_slot_e         slot);
    logic [PIX_W-1:0] c;
    logic [PIX_W-1:0] m;
    c = codes[int'(slot)*PIX_W +: PIX_W];
    m = unmask[int'(slot)*PIX_W +: PIX_W];
    return ((rx ^ c) & m) == '0;
  endfunction
endpackage

// File: rtl/cam_rx_sampler.sv
module cam_rx_sampler
  import cam_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             pix_clk,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic             rise_sel,
  output logic             strobe,
  output logic [PIX_W-1:0] s_data,
  output logic             s_hs,
  output logic             s_vs
);
  logic p1, p2;

  always_ff @(posedge clk) begin
    if (rst) begin
      p1     <= 1'b0;
      p2     <= 1'b0;
      s_data <= '0;
      s_hs   <= 1'b0;
      s_vs   <= 1'b0;
    end else begin
      p1     <= pix_clk;
      p2     <= p1;
      s_data <= pix_data;
      s_hs   <= hsync_in;
      s_vs   <= vsync_in;
    end
  end

  assign strobe = rise_sel ? (p1 & ~p2) : (~p1 & p2);

  // R2
  strobe_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> !strobe);
endmodule

// File: rtl/cam_rx_sync.sv
module cam_rx_sync
  import cam_rx_pkg::*;
#(
  parameter int unsigned GAP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               en,
  input  logic               emb,
  input  logic               hs_hi,
  input  logic               vs_hi,
  input  logic [CODES_W-1:0] codes,
  input  logic [CODES_W-1:0] unmask,
  input  logic [GAP_W-1:0]   gap_lim,
  input  logic               strobe,
  input  logic [PIX_W-1:0]   s_data,
  input  logic               s_hs,
  input  logic               s_vs,
  output logic               byte_v,
  output logic [PIX_W-1:0]   byte_d,
  output cam_evt_t           evt
);
  localparam int unsigned HIST_N = 3;

  logic [HIST_N-1:0][PIX_W-1:0] hist;   // [0] is the oldest byte
  logic [HIST_N-1:0]            hv;
  logic                         in_line, frame_open, la_d, fa_d;
  logic [GAP_W-1:0]             gap_cnt;

  logic pre, infer, hit_ls, hit_le, hit_fs, hit_fe, ev_code;
  logic line_now, frame_now;

  assign pre = (&hv) && (hist[0] == '1) && (hist[1] == '0) && (hist[2] == '0);
  assign infer = (codes[CODES_W-1 -: PIX_W] == '1) && (codes[PIX_W-1:0] == '1);
  assign hit_ls = code_hit(s_data, codes, unmask, SLOT_LS);
  assign hit_le = code_hit(s_data, codes, unmask, SLOT_LE);
  assign hit_fs = code_hit(s_data, codes, unmask, SLOT_FS);
  assign hit_fe = code_hit(s_data, codes, unmask, SLOT_FE);
  assign ev_code = pre && (hit_ls || hit_le || (!infer && (hit_fs || hit_fe)));
  assign frame_now = (s_vs == vs_hi);
  assign line_now  = (s_hs == hs_hi) && frame_now;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      hist       <= '0;
      hv         <= '0;
      in_line    <= 1'b0;
      frame_open <= 1'b0;
      la_d       <= 1'b0;
      fa_d       <= 1'b0;
      gap_cnt    <= '0;
      byte_v     <= 1'b0;
      byte_d     <= '0;
      evt        <= '0;
    end else begin
      byte_v <= 1'b0;
      evt    <= '0;
      if (strobe) begin
        if (emb) begin
          if (ev_code) begin
            hv <= '0;
            if (hit_ls) begin
              evt.sol <= 1'b1;
              in_line <= 1'b1;
              gap_cnt <= '0;
              if (infer && !frame_open) begin
                evt.sof    <= 1'b1;
                frame_open <= 1'b1;
              end
            end else if (hit_le) begin
              evt.eol <= in_line;
              in_line <= 1'b0;
              gap_cnt <= '0;
            end else if (hit_fs) begin
              evt.sof    <= 1'b1;
              frame_open <= 1'b1;
            end else begin
              evt.eof    <= 1'b1;
              evt.eol    <= in_line;
              frame_open <= 1'b0;
              in_line    <= 1'b0;
            end
          end else begin
            byte_v <= hv[0] && in_line;
            byte_d <= hist[0];
            hist   <= {s_data, hist[2], hist[1]};
            hv     <= {1'b1, hv[2], hv[1]};
            if (infer && frame_open && !in_line) begin
              if (gap_cnt == gap_lim) begin
                evt.eof    <= 1'b1;
                frame_open <= 1'b0;
                gap_cnt    <= '0;
              end else begin
                gap_cnt <= gap_cnt + 1'b1;
              end
            end
          end
        end else begin
          byte_v  <= line_now;
          byte_d  <= s_data;
          evt.sof <= frame_now && !fa_d;
          evt.eof <= !frame_now && fa_d;
          evt.sol <= line_now && !la_d;
          evt.eol <= !line_now && la_d;
          la_d    <= line_now;
          fa_d    <= frame_now;
        end
      end
    end
  end

  // R1
  idle_when_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> (!byte_v && (evt == '0)));
  // R6
  byte_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    (byte_v && emb && en) |-> in_line);
  // R4
  frame_flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(evt.sof && evt.eof));
endmodule

// File: rtl/cam_rx_packer.sv
module cam_rx_packer
  import cam_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              swap,
  input  logic              byte_v,
  input  logic [PIX_W-1:0]  byte_d,
  input  cam_evt_t          evt_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word,
  output cam_evt_t          evt_out
);
  logic [PIX_W-1:0] half;
  logic             have;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      half      <= '0;
      have      <= 1'b0;
      out_valid <= 1'b0;
      out_word  <= '0;
      evt_out   <= '0;
    end else begin
      out_valid <= 1'b0;
      evt_out   <= evt_in;
      if (evt_in.sol) begin
        have <= byte_v;
        half <= byte_d;
      end else if (evt_in.eol) begin
        have <= 1'b0;
      end else if (byte_v) begin
        if (have) begin
          out_valid <= 1'b1;
          out_word  <= swap ? {half, byte_d} : {byte_d, half};
          have      <= 1'b0;
        end else begin
          half <= byte_d;
          have <= 1'b1;
        end
      end
    end
  end

  // R9
  word_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

// File: rtl/cam_par_rx.sv
module cam_par_rx
  import cam_rx_pkg::*;
#(
  parameter int unsigned GAP_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pix_clk,
  input  logic [PIX_W-1:0]   pix_data,
  input  logic               hsync_in,
  input  logic               vsync_in,
  input  logic               cfg_enable,
  input  logic               cfg_embedded,
  input  logic               cfg_pclk_rise,
  input  logic               cfg_hs_high,
  input  logic               cfg_vs_high,
  input  logic               cfg_swap,
  input  logic [CODES_W-1:0] cfg_codes,
  input  logic [CODES_W-1:0] cfg_unmask,
  input  logic [GAP_W-1:0]   cfg_gap,
  output logic               out_valid,
  output logic [WORD_W-1:0]  out_word,
  output logic               out_sol,
  output logic               out_eol,
  output logic               out_sof,
  output logic               out_eof
);
  logic             strobe, s_hs, s_vs, byte_v;
  logic [PIX_W-1:0] s_data, byte_d;
  cam_evt_t         evt_s, evt_o;

  cam_rx_sampler u_sampler (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .pix_data(pix_data),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .rise_sel(cfg_pclk_rise),
    .strobe(strobe), .s_data(s_data), .s_hs(s_hs), .s_vs(s_vs)
  );

  cam_rx_sync #(.GAP_W(GAP_W)) u_sync (
    .clk(clk), .rst(rst), .en(cfg_enable), .emb(cfg_embedded),
    .hs_hi(cfg_hs_high), .vs_hi(cfg_vs_high), .codes(cfg_codes),
    .unmask(cfg_unmask), .gap_lim(cfg_gap), .strobe(strobe),
    .s_data(s_data), .s_hs(s_hs), .s_vs(s_vs),
    .byte_v(byte_v), .byte_d(byte_d), .evt(evt_s)
  );

  cam_rx_packer u_packer (
    .clk(clk), .rst(rst), .en(cfg_enable), .swap(cfg_swap),
    .byte_v(byte_v), .byte_d(byte_d), .evt_in(evt_s),
    .out_valid(out_valid), .out_word(out_word), .evt_out(evt_o)
  );

  assign out_sol = evt_o.sol;
  assign out_eol = evt_o.eol;
  assign out_sof = evt_o.sof;
  assign out_eof = evt_o.eof;
endmodule

// File: tb/cam_par_rx_bench.sv
module cam_par_rx_bench;
  localparam int K_WORD = 0, K_SOL = 1, K_EOL = 2, K_SOF = 3, K_EOF = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        pix_clk = 1'b0;
  logic [7:0]  pix_data = 8'h00;
  logic        hsync_in = 1'b0, vsync_in = 1'b0;
  logic        cfg_enable = 1'b0, cfg_embedded = 1'b0, cfg_pclk_rise = 1'b1;
  logic        cfg_hs_high = 1'b1, cfg_vs_high = 1'b1, cfg_swap = 1'b0;
  logic [31:0] cfg_codes = 32'hFF9D80FF, cfg_unmask = 32'hFFFFFFFF;
  logic [15:0] cfg_gap = 16'd8;
  logic        out_valid, out_sol, out_eol, out_sof, out_eof;
  logic [15:0] out_word;

  int    n_checks = 0;
  int    n_errors = 0;
  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cam_par_rx u_cam_par_rx (
    .clk(clk), .rst(rst), .pix_clk(pix_clk), .pix_data(pix_data),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .cfg_enable(cfg_enable),
    .cfg_embedded(cfg_embedded), .cfg_pclk_rise(cfg_pclk_rise),
    .cfg_hs_high(cfg_hs_high), .cfg_vs_high(cfg_vs_high), .cfg_swap(cfg_swap),
    .cfg_codes(cfg_codes), .cfg_unmask(cfg_unmask), .cfg_gap(cfg_gap),
    .out_valid(out_valid), .out_word(out_word), .out_sol(out_sol),
    .out_eol(out_eol), .out_sof(out_sof), .out_eof(out_eof)
  );

  task automatic push(input int kind, input logic [15:0] w, input string tag);
    exp_q.push_back({kind[2:0], w});
    tag_q.push_back(tag);
  endtask

  task automatic got(input int kind, input logic [15:0] w);
    logic [18:0] e;
    string t;
    n_checks++;
    if (exp_q.size() == 0) begin
      n_errors++;
      $display("FAIL unexpected output: kind=%0d word=%h expected nothing", kind, w);
    end else begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      if (e[18:16] != kind[2:0] || (kind == K_WORD && e[15:0] != w)) begin
        n_errors++;
        $display("FAIL %s: got kind=%0d word=%h expected kind=%0d word=%h",
                 t, kind, w, e[18:16], e[15:0]);
      end
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (out_sof)   got(K_SOF, 16'h0);
      if (out_sol)   got(K_SOL, 16'h0);
      if (out_valid) got(K_WORD, out_word);
      if (out_eol)   got(K_EOL, 16'h0);
      if (out_eof)   got(K_EOF, 16'h0);
    end
  end

  // one byte on the bus; junk is present around the edge that must not capture
  task automatic send(input logic [7:0] d, input logic hs_act, input logic vs_act);
    logic lvl;
    lvl = cfg_pclk_rise;
    @(negedge clk);
    pix_clk  = ~lvl;
    pix_data = ~d;
    hsync_in = hs_act ? cfg_hs_high : ~cfg_hs_high;
    vsync_in = vs_act ? cfg_vs_high : ~cfg_vs_high;
    repeat (2) @(negedge clk);
    pix_data = d;
    repeat (2) @(negedge clk);
    pix_clk = lvl;
    repeat (1) @(negedge clk);
  endtask

  task automatic eb(input logic [7:0] d);
    send(d, 1'b0, 1'b0);
  endtask

  task automatic code(input logic [7:0] c);
    eb(8'hFF); eb(8'h00); eb(8'h00); eb(c);
  endtask

  task automatic drain_check(input string tag);
    repeat (20) @(negedge clk);
    n_checks++;
    if (exp_q.size() != 0) begin
      n_errors++;
      $display("FAIL %s: %0d expected items missing, expected 0", tag, exp_q.size());
      exp_q.delete();
      tag_q.delete();
    end
  endtask

  task automatic setup(input logic emb, input logic rise, input logic hs_hi,
                       input logic vs_hi, input logic swap);
    @(negedge clk);
    cfg_enable    = 1'b0;
    cfg_embedded  = emb;
    cfg_pclk_rise = rise;
    cfg_hs_high   = hs_hi;
    cfg_vs_high   = vs_hi;
    cfg_swap      = swap;
    pix_clk       = ~rise;
    hsync_in      = ~hs_hi;
    vsync_in      = ~vs_hi;
    repeat (4) @(negedge clk);
    cfg_enable = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    report();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    n_checks++;
    if (out_valid || out_sol || out_eol || out_sof || out_eof) begin
      n_errors++;
      $display("FAIL R1: outputs after reset=%b expected 00000",
               {out_valid, out_sol, out_eol, out_sof, out_eof});
    end

    // R1: disabled capture ignores a whole external frame
    send(8'h01, 0, 1); send(8'h02, 1, 1); send(8'h03, 1, 1); send(8'h04, 0, 0);
    drain_check("R1 disabled");

    // R3 R4 R9: external syncs, active high, rising edge, no swap
    setup(1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    push(K_SOF, 0, "R4 sof"); push(K_SOL, 0, "R4 sol");
    push(K_WORD, 16'h2211, "R9 order"); push(K_WORD, 16'h4433, "R9 order");
    push(K_EOL, 0, "R4 eol"); push(K_SOL, 0, "R4 sol2");
    push(K_WORD, 16'h6655, "R9 restart"); push(K_WORD, 16'h8877, "R9 restart");
    push(K_EOL, 0, "R9 odd dropped"); push(K_EOF, 0, "R4 eof");
    send(8'hE0, 0, 1);
    send(8'h11, 1, 1); send(8'h22, 1, 1); send(8'h33, 1, 1); send(8'h44, 1, 1);
    send(8'hE1, 0, 1); send(8'hE2, 0, 1);
    send(8'h55, 1, 1); send(8'h66, 1, 1); send(8'h77, 1, 1); send(8'h88, 1, 1);
    send(8'h99, 1, 1);
    send(8'hE3, 0, 1); send(8'hE4, 0, 0); send(8'hE5, 0, 0);
    drain_check("R3 R4 external frame");

    // R2 R3 R10: falling edge, active-low syncs, swapped pairs
    setup(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    push(K_SOF, 0, "R3 sof low"); push(K_SOL, 0, "R3 sol low");
    push(K_WORD, 16'hA1B2, "R10 swap"); push(K_WORD, 16'hC3D4, "R2 fall edge");
    push(K_EOL, 0, "R3 eol low"); push(K_EOF, 0, "R3 eof low");
    send(8'h00, 0, 1);
    send(8'hA1, 1, 1); send(8'hB2, 1, 1); send(8'hC3, 1, 1); send(8'hD4, 1, 1);
    send(8'h00, 0, 1); send(8'h00, 0, 0);
    drain_check("R2 R10 falling edge");

    // R6 R7 R12: embedded, inferred frame limits
    cfg_codes = 32'hFF9D80FF; cfg_unmask = 32'hFFFFFFFF; cfg_gap = 16'd8;
    setup(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    push(K_SOF, 0, "R7 inferred sof"); push(K_SOL, 0, "R6 line start");
    push(K_WORD, 16'h00FF, "R12 data preamble"); push(K_WORD, 16'h5500, "R12 data byte");
    push(K_WORD, 16'h2010, "R6 data"); push(K_EOL, 0, "R6 line end");
    push(K_SOL, 0, "R7 short gap no eof"); push(K_WORD, 16'h4030, "R6 data2");
    push(K_EOL, 0, "R6 line end2"); push(K_EOF, 0, "R7 gap eof");
    eb(8'h10); eb(8'h20);
    code(8'h80);
    eb(8'hFF); eb(8'h00); eb(8'h00); eb(8'h55); eb(8'h10); eb(8'h20);
    code(8'h9D);
    code(8'h80);
    eb(8'h30); eb(8'h40);
    code(8'h9D);
    for (int i = 0; i < 12; i++) eb(8'h10);
    drain_check("R7 inferred frame");

    // R5 R8: explicit frame codes, line start hit through its unmask byte
    cfg_codes = 32'hF19D80AB; cfg_unmask = 32'hFFFFF0FF;
    setup(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    push(K_SOF, 0, "R8 frame code"); push(K_SOL, 0, "R5 masked line start");
    push(K_WORD, 16'h3412, "R5 data"); push(K_EOL, 0, "R8 line end");
    push(K_EOF, 0, "R8 frame end code");
    eb(8'h07);
    code(8'hAB);
    code(8'h8C);
    eb(8'h12); eb(8'h34);
    code(8'h9D);
    for (int i = 0; i < 12; i++) eb(8'h10);
    code(8'hF1);
    drain_check("R5 R8 explicit codes");

    // R11: disable in mid-line discards the line
    cfg_codes = 32'hFF9D80FF; cfg_unmask = 32'hFFFFFFFF;
    setup(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    push(K_SOF, 0, "R11 sof"); push(K_SOL, 0, "R11 sol");
    push(K_WORD, 16'h0201, "R11 word before disable");
    code(8'h80);
    eb(8'h01); eb(8'h02); eb(8'h03); eb(8'h04); eb(8'h05); eb(8'h06);
    repeat (5) @(negedge clk);
    cfg_enable = 1'b0;
    repeat (10) @(negedge clk);
    cfg_enable = 1'b1;
    eb(8'h07); eb(8'h08); eb(8'h09); eb(8'h0A);
    code(8'h9D);
    drain_check("R11 after re-enable");

    report();
    $finish;
  end
endmodule